// File: doc/BRIEF.md
# Four-Lane Receive Deskew Unit

This block sits after word alignment on a four-lane receive link that runs on one recovered clock. Each lane delivers one byte per cycle, a control flag and a sync-status bit. Each lane has its own small FIFO. A lane begins writing into its FIFO only when its first align code group arrives. The read side of every FIFO stays frozen until all four lanes have caught their align code within a bounded window. All reads are then released in the same cycle, so the four outputs carry words that were sent in the same column.

After release, the block watches the columns at the FIFO outputs. A column is aligned when all four lanes show the align code together. It is misaligned when some lanes show it but not all. Separate hysteresis counts turn the channel-aligned status on and off. If any lane loses sync, the unit clears itself and waits for a new align code.

Top module: `lane_deskew4`

## Requirements
- R1: Four lanes, each with a 16-entry FIFO. After release, lane i drives (flag, byte) in the same order it received them, and every lane shows words from the same transmit column.
- R2: When any sync_in bit is low, nothing is stored and dsk_valid stays 0, even while align codes arrive.
- R3: The align code is rx_ctrl=1 with byte 0x7C. dsk_valid rises two cycles after the cycle in which the last lane receives its first align code. The first valid column is the align code on every lane.
- R4: The last lane's first align code is accepted if it arrives up to 9 cycles after the first lane's. If it arrives 10 or more cycles later, or if a write would overrun a FIFO, all pointers reset, no output is released, and the unit waits for a new align code.
- R5: dsk_valid is 0 before release. After release it stays 1 until reset or loss of sync.
- R6: A column is aligned when dsk_valid is 1 and all four lanes output the align code. chan_aligned rises one cycle after the fourth consecutive aligned column.
- R7: Before alignment is acquired, a misaligned column (dsk_valid=1, align code on at least one lane but not all) restarts the aligned-column count.
- R8: Once chan_aligned is 1, it falls one cycle after the fourth misaligned column that has no aligned column between. An aligned column clears the misaligned count.
- R9: A low sync_in bit in cycle t forces dsk_valid and chan_aligned to 0 from cycle t+1, clears the FIFOs and returns the unit to waiting.
- R10: After reset, and whenever dsk_valid is 0, dsk_data, dsk_ctrl and chan_aligned are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared recovered clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 4 | Per-lane sync status, bit i for lane i |
| rx_data | input | 32 | Lane bytes, lane i at bits 8i+7..8i |
| rx_ctrl | input | 4 | Per-lane control flag |
| dsk_data | output | 32 | Deskewed lane bytes, same packing as rx_data |
| dsk_ctrl | output | 4 | Deskewed control flags |
| dsk_valid | output | 1 | Deskewed outputs are valid |
| chan_aligned | output | 1 | Channel alignment status |

## Verification
Two events can fall in the same cycle: the skew window closes, and the last lane receives its align code. Directed runs provoke this by placing the last lane's align code exactly 9 cycles after the first lane's, and then exactly 10 cycles after. The run at 9 must release with an align column on every lane two cycles later. The run at 10 must never raise dsk_valid. Randomized runs add skews of 0 to 9 cycles, partial align columns and a mid-stream sync drop. Every output cycle is compared with the column the bench itself sent.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;
  typedef enum logic [1:0] {
    DSK_IDLE = 2'd0,
    DSK_FILL = 2'd1,
    DSK_RUN  = 2'd2
  } dsk_state_e;
endpackage

// File: rtl/deskew_fifo.sv
module deskew_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
      rdata <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (rd_en) begin
        rdata <= mem[rptr];
        rptr  <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      end
      case ({wr_en, rd_en})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl import lane_deskew_pkg::*; #(
  parameter int LANES  = 4,
  parameter int WINDOW = 10,
  localparam int WW    = $clog2(WINDOW + 1)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [LANES-1:0] a_seen,
  input  logic [LANES-1:0] lane_full,
  output logic [LANES-1:0] wr_en,
  output logic             abort,
  output logic             run
);
  dsk_state_e       state_q, state_d;
  logic [LANES-1:0] started_q, started_d, start_nx;
  logic [WW-1:0]    win_q, win_d;

  always_comb begin
    start_nx  = started_q | a_seen;
    wr_en     = '0;
    abort     = 1'b0;
    state_d   = state_q;
    started_d = started_q;
    win_d     = win_q;
    case (state_q)
      DSK_IDLE: begin
        wr_en = a_seen;
        if (|a_seen) begin
          started_d = a_seen;
          win_d     = WW'(1);
          state_d   = (&a_seen) ? DSK_RUN : DSK_FILL;
        end
      end
      DSK_FILL: begin
        wr_en     = start_nx;
        started_d = start_nx;
        if (|(start_nx & lane_full))          abort   = 1'b1;
        else if (&start_nx)                   state_d = DSK_RUN;
        else if (win_q >= WW'(WINDOW - 1))    abort   = 1'b1;
        else                                  win_d   = win_q + WW'(1);
      end
      DSK_RUN:  wr_en = '1;
      default:  state_d = DSK_IDLE;
    endcase
    if (abort) begin
      state_d   = DSK_IDLE;
      started_d = '0;
      win_d     = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      state_q   <= DSK_IDLE;
      started_q <= '0;
      win_q     <= '0;
    end else begin
      state_q   <= state_d;
      started_q <= started_d;
      win_q     <= win_d;
    end
  end

  assign run = (state_q == DSK_RUN);
endmodule

// File: rtl/align_mon.sv
module align_mon #(
  parameter int ACQ_COLS  = 4,
  parameter int LOSS_COLS = 4,
  localparam int MAXC     = (ACQ_COLS > LOSS_COLS) ? ACQ_COLS : LOSS_COLS,
  localparam int CW       = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic clr,
  input  logic col_full,
  input  logic col_part,
  output logic locked
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr) begin
      locked <= 1'b0;
      cnt    <= '0;
    end else if (!locked) begin
      if (col_full) begin
        if (cnt == CW'(ACQ_COLS - 1)) begin
          locked <= 1'b1;
          cnt    <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end else if (col_part) begin
        cnt <= '0;
      end
    end else begin
      if (col_full) begin
        cnt <= '0;
      end else if (col_part) begin
        if (cnt == CW'(LOSS_COLS - 1)) begin
          locked <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lane_deskew4.sv
module lane_deskew4 #(
  parameter int LANES     = 4,
  parameter int DW        = 8,
  parameter int DEPTH     = 16,
  parameter int WINDOW    = 10,
  parameter int ACQ_COLS  = 4,
  parameter int LOSS_COLS = 4,
  parameter logic [DW-1:0] ALIGN_CODE = DW'(8'h7C)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LANES-1:0]    sync_in,
  input  logic [LANES*DW-1:0] rx_data,
  input  logic [LANES-1:0]    rx_ctrl,
  output logic [LANES*DW-1:0] dsk_data,
  output logic [LANES-1:0]    dsk_ctrl,
  output logic                dsk_valid,
  output logic                chan_aligned
);
  localparam int FW  = DW + 1;
  localparam int LVW = $clog2(DEPTH + 1);

  logic                  clr, abort, run, fifo_clr, valid_q;
  logic                  col_full, col_part;
  logic [LANES-1:0]      a_seen, lane_full, wr_en, out_a;
  logic [LANES*LVW-1:0]  lvl_all;

  assign clr      = rst | ~(&sync_in);
  assign fifo_clr = clr | abort;

  deskew_ctrl #(.LANES(LANES), .WINDOW(WINDOW)) u_ctrl (
    .clk       (clk),
    .clr       (clr),
    .a_seen    (a_seen),
    .lane_full (lane_full),
    .wr_en     (wr_en),
    .abort     (abort),
    .run       (run)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [FW-1:0]  rd_word;
    logic [LVW-1:0] lvl;

    assign a_seen[g] = rx_ctrl[g] && (rx_data[g*DW +: DW] == ALIGN_CODE);

    deskew_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .clr   (fifo_clr),
      .wr_en (wr_en[g]),
      .rd_en (run),
      .wdata ({rx_ctrl[g], rx_data[g*DW +: DW]}),
      .rdata (rd_word),
      .level (lvl)
    );

    assign lane_full[g]            = (lvl == LVW'(DEPTH));
    assign lvl_all[g*LVW +: LVW]   = lvl;
    assign dsk_data[g*DW +: DW]    = valid_q ? rd_word[DW-1:0] : '0;
    assign dsk_ctrl[g]             = valid_q & rd_word[DW];
    assign out_a[g]                = dsk_ctrl[g] && (dsk_data[g*DW +: DW] == ALIGN_CODE);
  end

  always_ff @(posedge clk) begin
    if (clr) valid_q <= 1'b0;
    else     valid_q <= run;
  end

  assign dsk_valid = valid_q;
  assign col_full  = &out_a;
  assign col_part  = (|out_a) & ~(&out_a);

  align_mon #(.ACQ_COLS(ACQ_COLS), .LOSS_COLS(LOSS_COLS)) u_mon (
    .clk      (clk),
    .clr      (clr),
    .col_full (col_full),
    .col_part (col_part),
    .locked   (chan_aligned)
  );
endmodule

// File: rtl/lane_deskew4_chk.sv
module lane_deskew4_chk #(
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic                clk,
  input logic                rst,
  input logic [LANES-1:0]    sync_in,
  input logic                dsk_valid,
  input logic                chan_aligned,
  input logic                col_full,
  input logic                col_part,
  input logic [LANES*CW-1:0] lvl_all
);
  p_valid_needs_sync_r2: assert property (@(posedge clk) disable iff (rst)
    dsk_valid |-> $past(&sync_in));

  p_valid_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (dsk_valid && (&sync_in)) |=> dsk_valid);

  p_drop_clears_r9: assert property (@(posedge clk) disable iff (rst)
    !(&sync_in) |=> (!dsk_valid && !chan_aligned));

  p_lock_needs_valid_r6: assert property (@(posedge clk) disable iff (rst)
    chan_aligned |-> $past(dsk_valid));

  p_lock_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(chan_aligned) |-> $past(col_full));

  p_lock_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(chan_aligned) |-> ($past(col_part) || !$past(&sync_in)));

  for (genvar g = 0; g < LANES; g++) begin : g_lvl
    p_no_overrun_r4: assert property (@(posedge clk) disable iff (rst)
      lvl_all[g*CW +: CW] <= CW'(DEPTH));
  end
endmodule

bind lane_deskew4 lane_deskew4_chk #(.LANES(LANES), .DEPTH(DEPTH), .CW(LVW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sync_in      (sync_in),
  .dsk_valid    (dsk_valid),
  .chan_aligned (chan_aligned),
  .col_full     (col_full),
  .col_part     (col_part),
  .lvl_all      (lvl_all)
);

// File: tb/lane_deskew4_test.sv
module lane_deskew4_test;
  localparam int NCOL   = 100;
  localparam int WIN    = 10;
  localparam int ACQ    = 4;
  localparam int LOSS   = 4;
  localparam logic [7:0] KA = 8'h7C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  sync_in = 4'hF;
  logic [31:0] rx_data = '0;
  logic [3:0]  rx_ctrl = '0;
  logic [31:0] dsk_data;
  logic [3:0]  dsk_ctrl;
  logic        dsk_valid, chan_aligned;

  int checks = 0;
  int errors = 0;
  int a0 = 0;
  logic [7:0] sd [NCOL][4];
  logic       sk [NCOL][4];

  always #2 clk = ~clk;

  lane_deskew4 uut (
    .clk(clk), .rst(rst), .sync_in(sync_in), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
    .dsk_data(dsk_data), .dsk_ctrl(dsk_ctrl), .dsk_valid(dsk_valid), .chan_aligned(chan_aligned)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit is_a(input logic [7:0] b, input logic k);
    return k && (b == KA);
  endfunction

  function automatic void rnd_word(output logic [7:0] b, output logic k);
    b = 8'($urandom);
    k = ($urandom % 4) == 0;
    if (k && b == KA) b = 8'h7D;
  endfunction

  // mode 0: all align columns full; 1: random partial; 2: full then partial; 3: one align column
  task automatic gen_src(input int mode);
    a0 = 2 + int'($urandom % 4);
    for (int c = 0; c < NCOL; c++) begin
      for (int i = 0; i < 4; i++) rnd_word(sd[c][i], sk[c][i]);
      if (c == a0 || (c > a0 && (c - a0) % 6 == 0 && mode != 3)) begin
        bit full;
        logic [3:0] pm;
        full = (c == a0) || mode == 0 || (mode == 1 && ($urandom % 10) < 7) ||
               (mode == 2 && (c - a0) / 6 < 5);
        pm = full ? 4'hF : 4'(1 + $urandom % 14);
        for (int i = 0; i < 4; i++)
          if (pm[i]) begin sd[c][i] = KA; sk[c][i] = 1'b1; end
      end
    end
  endtask

  task automatic run_stream(input int d0, input int d1, input int d2, input int d3, input int mode,
                            input bit lone, input logic [3:0] smask, input int drop_at);
    int d[4];
    int dmax, dmin, off, tr, m, idx, mcnt, dl;
    bit ok, vexp, mlock;
    logic [3:0] am;
    string vtag, atag;
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    dmax = d0; dmin = d0;
    for (int i = 1; i < 4; i++) begin
      if (d[i] > dmax) dmax = d[i];
      if (d[i] < dmin) dmin = d[i];
    end
    gen_src(mode);
    off   = lone ? 20 : 0;
    tr    = off + a0 + dmax;
    ok    = (dmax - dmin <= WIN - 1) && (smask == 4'hF);
    mlock = 1'b0;
    mcnt  = 0;
    dl    = int'($urandom % 4);
    atag  = (mode == 1) ? "R7" : (mode == 2) ? "R8" : "R6";
    rst = 1'b1; sync_in = 4'hF; rx_ctrl = '0; rx_data = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int t = 0; t <= off + NCOL + dmax; t++) begin
      @(negedge clk);
      if (t > 0) begin
        m = t - 1;
        if (drop_at >= 0 && m >= drop_at) begin
          if (m <= drop_at + 1) begin
            chk(dsk_valid == 1'b0, "R9", "valid after sync drop", dsk_valid, 0);
            chk(chan_aligned == 1'b0, "R9", "aligned after sync drop", chan_aligned, 0);
          end
        end else begin
          vexp = ok && (m >= tr + 1);
          vtag = (smask != 4'hF) ? "R2" : !ok ? "R4" : (m == tr + 1) ? "R3" : "R5";
          chk(dsk_valid == vexp, vtag, "dsk_valid", dsk_valid, vexp);
          chk(chan_aligned == mlock, atag, "chan_aligned", chan_aligned, mlock);
          if (vexp) begin
            idx = m - off - 1 - dmax;
            for (int i = 0; i < 4; i++) begin
              chk(dsk_data[i*8 +: 8] == sd[idx][i], "R1", $sformatf("lane%0d byte", i),
                  dsk_data[i*8 +: 8], sd[idx][i]);
              chk(dsk_ctrl[i] == sk[idx][i], "R1", $sformatf("lane%0d flag", i),
                  dsk_ctrl[i], sk[idx][i]);
              am[i] = is_a(sd[idx][i], sk[idx][i]);
            end
            if (m == tr + 1) chk(&am, "R3", "first column is align", am, 15);
            if (&am) begin
              if (!mlock) begin
                if (mcnt == ACQ - 1) begin mlock = 1'b1; mcnt = 0; end else mcnt++;
              end else mcnt = 0;
            end else if (|am) begin
              if (!mlock) mcnt = 0;
              else if (mcnt == LOSS - 1) begin mlock = 1'b0; mcnt = 0; end
              else mcnt++;
            end
          end else begin
            chk(dsk_data == '0 && dsk_ctrl == '0, "R10", "outputs idle zero", dsk_data, 0);
          end
        end
      end
      sync_in = (t == drop_at) ? (smask & ~(4'b1 << dl)) : smask;
      for (int i = 0; i < 4; i++) begin
        logic [7:0] b;
        logic k;
        idx = t - off - d[i];
        if (lone && t == 0 && i == 0) begin b = KA; k = 1'b1; end
        else if (idx >= 0 && idx < NCOL) begin b = sd[idx][i]; k = sk[idx][i]; end
        else rnd_word(b, k);
        rx_data[i*8 +: 8] = b;
        rx_ctrl[i] = k;
      end
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(dsk_valid == 1'b0, "R10", "reset valid", dsk_valid, 0);
    chk(chan_aligned == 1'b0, "R10", "reset aligned", chan_aligned, 0);
    chk(dsk_data == '0 && dsk_ctrl == '0, "R10", "reset data", dsk_data, 0);
    // directed skews, including the window edge (R4)
    run_stream(0, 0, 0, 0, 0, 1'b0, 4'hF, -1);
    run_stream(0, 3, 7, 9, 0, 1'b0, 4'hF, -1);
    run_stream(9, 0, 0, 0, 3, 1'b0, 4'hF, -1);
    run_stream(0, 0, 0, 10, 3, 1'b0, 4'hF, -1);
    run_stream(10, 0, 2, 0, 3, 1'b0, 4'hF, -1);
    // R2: one lane out of sync
    run_stream(0, 1, 2, 3, 0, 1'b0, 4'b1011, -1);
    // R4: lone align code times out, later stream still deskews
    run_stream(2, 5, 0, 4, 0, 1'b1, 4'hF, -1);
    // constrained random skews with mixed column patterns
    for (int r = 0; r < 8; r++)
      run_stream(int'($urandom % 10), int'($urandom % 10), int'($urandom % 10),
                 int'($urandom % 10), (r % 3), 1'b0, 4'hF, -1);
    // R9: sync drop mid-stream after lock
    run_stream(int'($urandom % 10), int'($urandom % 10), 1, 6, 0, 1'b0, 4'hF, 90);
    finish_run();
  end
endmodule